// File: doc/BRIEF.md
# Eight-bit tick timer with one compare channel

The block is an 8-bit timer/counter for a CPU subsystem. A free-running prescaler makes a tick enable, and a 3-bit clock select chooses its rate. On each tick the count rises, falls or resets to zero, as the mode field selects. One comparator checks the count against a compare register. A match raises a compare flag and can toggle a compare output pin. Wrapping at the end of the count range raises an overflow flag.

The CPU reaches four registers over a small synchronous bus: control, count, compare and flags. Each flag drives an interrupt request, gated by its own enable and by a global enable. A flag is cleared by writing a one to its bit or by pulsing that flag's acknowledge input. Status outputs show when the count sits at its top (0xFF) or at its bottom (0x00).

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, every register (control, count, compare, flags), the compare output and both interrupt requests read zero.
- R2: Clock select 0 stops the counter, and the count still reads and writes normally. Select values 1 to 7 give a tick on the cycles where the low k bits of a free-running prescaler are all ones. The prescaler is cleared by reset and rises by one every clock. k is 0, 3, 5, 6, 7, 8 and 10 for selects 1 to 7, which is divide-by 1, 8, 32, 64, 128, 256 and 1024.
- R3: A bus write to the count (address 1) loads the written value on the next cycle, whatever the tick would have done. Flag setting and output toggling in that cycle still follow the count held before the write.
- R4: Mode 0 (control bits 4:3 = 0): each tick adds one, and 0xFF wraps to 0x00. A tick at 0xFF sets the overflow flag.
- R5: Mode 1: counts up, and a tick while count equals compare loads zero. A tick at 0xFF sets the overflow flag.
- R6: Mode 2: each tick subtracts one, and 0x00 wraps to 0xFF. A tick at 0x00 sets the overflow flag.
- R7: Mode 3: every tick loads zero, and no overflow is flagged.
- R8: A tick taken while count equals compare sets the compare flag (flags bit 0), which is visible from the next cycle, in every mode.
- R9: Writing a one to a flags bit (address 3; bit 0 compare, bit 1 overflow) or pulsing that flag's acknowledge input clears it. A set in the same cycle wins over a clear.
- R10: The compare request is high exactly when the compare flag, control bit 6 and the global enable are all set. The overflow request works the same way with control bit 7.
- R11: The top output is high exactly when the count is 0xFF, and the bottom output is high exactly when it is 0x00.
- R12: With control bit 5 set, the compare output inverts on each tick taken during a match. Otherwise it holds its value.
- R13: Reads are combinational. Address 0 returns control (bits 2:0 select, 4:3 mode, 5 toggle, 6 compare enable, 7 overflow enable), address 2 returns compare, and address 3 returns the two flags in bits 1:0 with zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| ack_cmp | input | 1 | Compare interrupt acknowledge |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| cmp_out | output | 1 | Compare toggle output |
| at_top | output | 1 | Count equals maximum |
| at_bottom | output | 1 | Count equals zero |

## Verification
Directed sequences come first:
- Select 0 with writes shows that a stopped counter is not the same as a count that still changes.
- A start near 0xFE in up mode and near 0x01 in down mode checks each wrap and which side of it carries the overflow.
- A compare of 0xFF in clear-on-match mode separates the match clear from the natural wrap.
- A flag clear written on the same tick as a match checks which action wins.

Random bus traffic then mixes modes, the slower selects, acknowledges and the global enable. This exposes prescaler phase errors and off-by-one-tick flag timing against a cycle model of the registers.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int NUM_SEL = 7;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_UP_CLR = 2'd1,
        MODE_DOWN   = 2'd2,
        MODE_ZERO   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      ovf_ie;
        logic      cmp_ie;
        logic      tgl_en;
        tmr_mode_e mode;
        logic [2:0] csel;
    } tmr_ctrl_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } tmr_flags_t;

    localparam int NUM_FLAGS = $bits(tmr_flags_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    function automatic int div_shift(input int sel);
        case (sel)
            1: return 0;
            2: return 3;
            3: return 5;
            4: return 6;
            5: return 7;
            6: return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] csel,
    output logic       tick
);
    logic [PSC_W-1:0]   psc_q;
    logic [NUM_SEL:0]   taps;

    always_ff @(posedge clk) begin
        if (rst) psc_q <= '0;
        else     psc_q <= psc_q + 1'b1;
    end

    assign taps[0] = 1'b0;

    for (genvar i = 1; i <= NUM_SEL; i++) begin : g_tap
        localparam int SH = div_shift(i);
        localparam logic [PSC_W-1:0] MASK = PSC_W'((64'd1 << SH) - 64'd1);
        assign taps[i] = ((psc_q & MASK) == MASK);
    end

    assign tick = taps[csel];

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             tgl_en,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             at_top,
    output logic             at_bottom,
    output logic             cmp_evt,
    output logic             ovf_evt,
    output logic             cmp_out
);
    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q;

    assign match     = (cnt_q == cmp_val);
    assign at_top    = (cnt_q == TOP_VAL);
    assign at_bottom = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            case (mode)
                MODE_UP:     cnt_d = cnt_q + 1'b1;
                MODE_UP_CLR: cnt_d = match ? '0 : cnt_q + 1'b1;
                MODE_DOWN:   cnt_d = cnt_q - 1'b1;
                default:     cnt_d = '0;
            endcase
        end
        if (wr_cnt) cnt_d = wr_val;
    end

    assign cmp_evt = tick && match;
    assign ovf_evt = tick && ((((mode == MODE_UP) || (mode == MODE_UP_CLR)) && at_top)
                              || ((mode == MODE_DOWN) && at_bottom));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmp_evt && tgl_en) out_q <= ~out_q;
        end
    end

    assign cnt     = cnt_q;
    assign cmp_out = out_q;

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags
    import tmr8_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_evt,
    input  logic [NF-1:0] clr_req,
    output logic [NF-1:0] flag
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)             f_q <= 1'b0;
            else if (set_evt[i]) f_q <= 1'b1;
            else if (clr_req[i]) f_q <= 1'b0;
        end
        assign flag[i] = f_q;
    end
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PSC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             gie,
    input  logic             ack_cmp,
    input  logic             ack_ovf,
    output logic             irq_cmp,
    output logic             irq_ovf,
    output logic             cmp_out,
    output logic             at_top,
    output logic             at_bottom
);
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt;
    logic             tick, match, cmp_evt, ovf_evt;
    logic             wr_cnt;
    tmr_flags_t       flags, set_v, clr_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_addr == ADDR_CMP)  cmp_q  <= bus_wdata;
        end
    end

    assign wr_cnt = bus_wr && (bus_addr == ADDR_CNT);

    tmr8_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .csel (ctrl_q.csel),
        .tick (tick)
    );

    tmr8_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl_q.mode),
        .tgl_en    (ctrl_q.tgl_en),
        .cmp_val   (cmp_q),
        .wr_cnt    (wr_cnt),
        .wr_val    (bus_wdata),
        .cnt       (cnt),
        .match     (match),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .cmp_evt   (cmp_evt),
        .ovf_evt   (ovf_evt),
        .cmp_out   (cmp_out)
    );

    always_comb begin
        set_v.cmp = cmp_evt;
        set_v.ovf = ovf_evt;
        clr_v.cmp = ack_cmp || (bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0]);
        clr_v.ovf = ack_ovf || (bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[1]);
    end

    tmr8_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_v),
        .clr_req (clr_v),
        .flag    (flags)
    );

    assign irq_cmp = flags.cmp && ctrl_q.cmp_ie && gie;
    assign irq_ovf = flags.ovf && ctrl_q.ovf_ie && gie;

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl_q);
            ADDR_CNT:  bus_rdata = cnt;
            ADDR_CMP:  bus_rdata = cmp_q;
            default:   bus_rdata = CNT_W'(flags);
        endcase
    end

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             gie,
    input logic             irq_cmp,
    input logic             cmp_out,
    input logic             at_top,
    input logic             at_bottom,
    input logic             tick,
    input logic             match,
    input logic [CNT_W-1:0] cnt,
    input tmr_ctrl_t        ctrl_q,
    input tmr_flags_t       flags
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == ADDR_CNT);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(bus_wdata)));  // R3

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.csel == 3'd0 && !cnt_wr) |=> $stable(cnt));  // R2

    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tick && match) |=> flags.cmp);  // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_cmp |-> (gie && flags.cmp));  // R10

    AST_OUT_STILL: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cmp_out));  // R12

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.mode == MODE_UP && at_top && !cnt_wr) |=> (at_bottom && flags.ovf));  // R4

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.mode == MODE_DOWN && at_bottom && !cnt_wr) |=> (at_top && flags.ovf));  // R6

    AST_ZERO_MODE: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.mode == MODE_ZERO && !cnt_wr) |=> at_bottom);  // R7
endmodule

bind tmr8_cmp tmr8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .gie       (gie),
    .irq_cmp   (irq_cmp),
    .cmp_out   (cmp_out),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .tick      (tick),
    .match     (match),
    .cnt       (cnt),
    .ctrl_q    (ctrl_q),
    .flags     (flags)
);

// File: tb/tmr8_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_cmp_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0, ack_cmp = 1'b0, ack_ovf = 1'b0;
    logic       irq_cmp, irq_ovf, cmp_out, at_top, at_bottom;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_cnt, m_cmp, m_ctrl;
    logic       m_fc, m_fo, m_out;
    logic [9:0] m_psc;

    always #2.5 clk = ~clk;

    tmr8_cmp u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
        .ack_cmp(ack_cmp), .ack_ovf(ack_ovf), .irq_cmp(irq_cmp),
        .irq_ovf(irq_ovf), .cmp_out(cmp_out), .at_top(at_top),
        .at_bottom(at_bottom)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sel_shift(input logic [2:0] cs);
        case (cs)
            3'd1: return 0;
            3'd2: return 3;
            3'd3: return 5;
            3'd4: return 6;
            3'd5: return 7;
            3'd6: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic m_tick();
        logic [9:0] mask;
        if (m_ctrl[2:0] == 3'd0) return 1'b0;
        mask = 10'((1 << sel_shift(m_ctrl[2:0])) - 1);
        return (m_psc & mask) == mask;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_cnt;
            2'd2: return m_cmp;
            default: return {6'd0, m_fo, m_fc};
        endcase
    endfunction

    function automatic string cnt_tag();
        if (m_ctrl[2:0] == 3'd0) return "R2 count stopped";
        case (m_ctrl[4:3])
            2'd0: return "R4 up count";
            2'd1: return "R5 clear-on-match count";
            2'd2: return "R6 down count";
            default: return "R7 zero mode count";
        endcase
    endfunction

    // Drive one cycle (called at negedge), check, then advance the model.
    task automatic cyc(input logic [1:0] a, input logic w, input logic [7:0] d,
                       input logic g, input logic ac, input logic ao);
        logic       t, mt, cs, os, cc, co;
        logic [7:0] nc;
        bus_addr = a; bus_wr = w; bus_wdata = d; gie = g; ack_cmp = ac; ack_ovf = ao;
        #1;
        if (a == 2'd1)      check(cnt_tag(), bus_rdata, exp_rd(a));
        else if (a == 2'd3) check("R8/R9 flags readback", bus_rdata, exp_rd(a));
        else                check("R13 register readback", bus_rdata, exp_rd(a));
        check("R10 compare request", {7'd0, irq_cmp}, {7'd0, m_fc & m_ctrl[6] & g});
        check("R10 overflow request", {7'd0, irq_ovf}, {7'd0, m_fo & m_ctrl[7] & g});
        check("R11 top flag", {7'd0, at_top}, {7'd0, m_cnt == 8'hFF});
        check("R11 bottom flag", {7'd0, at_bottom}, {7'd0, m_cnt == 8'h00});
        check("R12 compare output", {7'd0, cmp_out}, {7'd0, m_out});
        t  = m_tick();
        mt = (m_cnt == m_cmp);
        nc = m_cnt;
        if (t) begin
            case (m_ctrl[4:3])
                2'd0: nc = m_cnt + 8'd1;
                2'd1: nc = mt ? 8'd0 : m_cnt + 8'd1;
                2'd2: nc = m_cnt - 8'd1;
                default: nc = 8'd0;
            endcase
        end
        cs = t && mt;
        os = t && (((m_ctrl[4:3] <= 2'd1) && m_cnt == 8'hFF) || (m_ctrl[4:3] == 2'd2 && m_cnt == 8'h00));
        cc = ac || (w && a == 2'd3 && d[0]);
        co = ao || (w && a == 2'd3 && d[1]);
        @(posedge clk);
        if (w && a == 2'd1) nc = d;
        if (cs && m_ctrl[5]) m_out = ~m_out;
        m_fc = cs ? 1'b1 : (cc ? 1'b0 : m_fc);
        m_fo = os ? 1'b1 : (co ? 1'b0 : m_fo);
        if (w && a == 2'd0) m_ctrl = d;
        if (w && a == 2'd2) m_cmp = d;
        m_cnt = nc;
        m_psc = m_psc + 10'd1;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(a, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(a, 1'b1, d, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_fc = 0; m_fo = 0; m_out = 0; m_psc = 0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            check("R1 reset register value", bus_rdata, 8'd0);
            check("R1 reset requests", {6'd0, irq_cmp, irq_ovf}, 8'd0);
            check("R1 reset compare output", {7'd0, cmp_out}, 8'd0);
            @(negedge clk);
        end
        rst = 1'b0;

        // R2: stopped counter keeps a written count
        wr(2'd1, 8'h05);
        idle(20, 2'd1);
        // R3: count writes while ticking at full rate
        wr(2'd0, 8'b1100_0001);
        for (int i = 0; i < 6; i++) wr(2'd1, 8'h10 + 8'(i));
        idle(4, 2'd1);
        // R4: up wrap sets overflow
        wr(2'd1, 8'hFE);
        idle(3, 2'd1);
        idle(1, 2'd3);
        wr(2'd3, 8'h02);
        idle(1, 2'd3);
        // R6: down wrap
        wr(2'd0, 8'b1101_0001);
        wr(2'd1, 8'h02);
        idle(4, 2'd1);
        idle(1, 2'd3);
        // R5: clear-on-match with compare at 0xFF, toggle on
        wr(2'd0, 8'b1110_1001);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFC);
        idle(6, 2'd1);
        idle(1, 2'd3);
        // R9: clear written on the matching tick loses to the set
        wr(2'd2, 8'h20);
        wr(2'd1, 8'h1F);
        idle(1, 2'd1);
        wr(2'd3, 8'h03);
        idle(1, 2'd3);
        cyc(2'd3, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1);
        idle(1, 2'd3);
        // R7: zero mode
        wr(2'd0, 8'b0001_1001);
        wr(2'd1, 8'h44);
        idle(3, 2'd1);
        // R2: slower divides
        wr(2'd0, 8'b0000_0010);
        idle(40, 2'd1);

        for (int i = 0; i < 5000; i++) begin
            logic [1:0] a;
            logic       w;
            logic [7:0] d;
            a = 2'($urandom % 4);
            w = ($urandom % 4) == 0;
            d = 8'($urandom);
            if (w && a == 2'd0) d[2:0] = 3'($urandom % 4);
            if (w && a == 2'd3 && ($urandom % 2) == 0) d = 8'd0;
            cyc(a, w, d, 1'($urandom % 2), ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule